// File: doc/BRIEF.md
# Keyed Register Write Guard

This block sits on a peripheral's register write path and decides, for each of a fixed set of configuration registers, whether a write may land. A mode register holds one protection bit. That bit can be changed only by a write whose upper 24 bits carry the fixed unlock key. While protection is on, writes aimed at the guarded registers are dropped. Each dropped write is recorded in a status register.

The status register holds a sticky violation flag and the byte offset of the most recent blocked write. Reading the status register returns its contents and clears it. The guarded registers themselves live outside this block. Each one takes its write strobe from the matching bit of `wr_allow`. The bus has separate read and write address lines, so a status read and a write can occur in the same cycle.

Top module: `wp_guard`

## Requirements
- R1: After reset, protection is off and the violation flag and source field are zero, so reads of the mode register (offset 0xE4) and of the status register (offset 0xE8) both return 0.
- R2: A write to offset 0xE4 whose bits 31:8 equal 0x535343 loads bit 0 of the write data into the protection bit. A value of 1 turns protection on and a value of 0 turns it off.
- R3: A write to offset 0xE4 with any other value in bits 31:8 leaves the protection bit unchanged.
- R4: A read of offset 0xE4 returns the protection bit at bit 0 and zero in every other bit, including the key field at bits 31:8.
- R5: While protection is off, a write to a guarded offset raises `wr_allow` in the same cycle as the write strobe and logs nothing. The guarded offsets are 0x04, 0x10, 0x14, 0x18, 0x1C, 0x38 and 0x3C, mapped in that order to `wr_allow` bits 0 to 6.
- R6: While protection is on, a write to a guarded offset keeps `wr_allow` at 0. It sets the violation flag, which reads at status bit 0, and records the offset in the source field, which reads at status bits 23:16 being zero and bits 15:8 holding the offset.
- R7: If several writes are blocked before the status register is read, the source field holds the offset of the most recent one.
- R8: A read of the status register returns its current contents and clears both the flag and the source field afterwards.
- R9: If a blocked write falls in the same cycle as a status read, the read returns the old contents, and afterwards the flag is set and the source field holds the new offset.
- R10: A write to an offset outside the guarded set and not 0xE4 never raises `wr_allow` and never logs a violation.
- R11: Read data appears in the cycle after the read strobe. It is 0 for offsets other than 0xE4 and 0xE8, and 0 in any cycle that follows a cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_waddr | input | 8 | Byte offset of the write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 8 | Byte offset of the read |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| wr_allow | output | 7 | Per-register qualified write strobe |

## Verification
The two functions that can meet in one cycle are logging a blocked write and clearing the log on a status read. The separate read and write addresses let a single bus cycle carry both. The bench first blocks a write to 0x1C. It then issues a status read together with a blocked write to 0x3C. It checks that the read returns the 0x1C record and that the next read returns the 0x3C record, which shows the clear did not erase the new entry. A further read confirms that the log then empties.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int unsigned OFS_W   = 8;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned KEY_W   = 24;
  localparam int unsigned SRC_W   = 16;
  localparam int unsigned N_GUARD = 7;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 24'h535343;
  localparam logic [OFS_W-1:0] MODE_OFS = 8'hE4;
  localparam logic [OFS_W-1:0] STAT_OFS = 8'hE8;
  // guarded offsets, entry i drives wr_allow[i]
  localparam logic [N_GUARD*OFS_W-1:0] GUARD_OFS =
    {8'h3C, 8'h38, 8'h1C, 8'h18, 8'h14, 8'h10, 8'h04};
endpackage

// File: rtl/wpg_match.sv
module wpg_match #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N      = 7,
  parameter logic [N*ADDR_W-1:0] MAP = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N-1:0]      hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = (addr == MAP[i*ADDR_W +: ADDR_W]);
  end
endmodule

// File: rtl/wpg_lock.sv
module wpg_lock #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned KEY_W  = 24,
  parameter logic [KEY_W-1:0]  KEY       = '0,
  parameter logic [ADDR_W-1:0] MODE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [KEY_W-1:0]  key_in,
  input  logic              en_in,
  output logic              lock_on
);
  logic key_ok;
  logic mode_wr;
  assign mode_wr = wr && (waddr == MODE_ADDR);
  assign key_ok  = (key_in == KEY);

  always_ff @(posedge clk) begin
    if (rst)                  lock_on <= 1'b0;
    else if (mode_wr && key_ok) lock_on <= en_in;
  end

  assert_badkey_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && waddr == MODE_ADDR && key_in != KEY) |=> $stable(lock_on));
  assert_goodkey_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && waddr == MODE_ADDR && key_in == KEY) |=> (lock_on == $past(en_in)));
endmodule

// File: rtl/wpg_vlog.sv
module wpg_vlog #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SRC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              viol,
  input  logic [ADDR_W-1:0] viol_addr,
  input  logic              clr,
  output logic              flag,
  output logic [SRC_W-1:0]  src
);
  // a fresh violation outranks the clear from a status read
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      src  <= '0;
    end else if (viol) begin
      flag <= 1'b1;
      src  <= SRC_W'(viol_addr);
    end else if (clr) begin
      flag <= 1'b0;
      src  <= '0;
    end
  end

  assert_log_R6: assert property (@(posedge clk) disable iff (rst)
    viol |=> (flag && src == SRC_W'($past(viol_addr))));
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr && !viol) |=> (!flag && src == '0));
  assert_collide_R9: assert property (@(posedge clk) disable iff (rst)
    (clr && viol) |=> flag);
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int unsigned ADDR_W = wpg_pkg::OFS_W,
  parameter int unsigned DATA_W = wpg_pkg::REG_W,
  parameter int unsigned KEY_W  = wpg_pkg::KEY_W,
  parameter int unsigned SRC_W  = wpg_pkg::SRC_W,
  parameter int unsigned N_PROT = wpg_pkg::N_GUARD,
  parameter logic [N_PROT*ADDR_W-1:0] PROT_MAP = wpg_pkg::GUARD_OFS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ADDR_W-1:0] bus_raddr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_PROT-1:0] wr_allow
);
  localparam int unsigned SRC_LSB = 8;
  localparam int unsigned UNUSED_W = DATA_W - KEY_W - 1;

  logic [N_PROT-1:0] hit;
  logic              lock_on;
  logic              viol;
  logic              stat_rd;
  logic              v_flag;
  logic [SRC_W-1:0]  v_src;
  logic [DATA_W-1:0] rd_word;
  logic [UNUSED_W-1:0] unused_wdata;

  assign unused_wdata = bus_wdata[UNUSED_W:1];

  wpg_match #(.ADDR_W(ADDR_W), .N(N_PROT), .MAP(PROT_MAP)) u_match (
    .addr (bus_waddr),
    .hit  (hit)
  );

  wpg_lock #(.ADDR_W(ADDR_W), .KEY_W(KEY_W),
             .KEY(wpg_pkg::UNLOCK_KEY), .MODE_ADDR(wpg_pkg::MODE_OFS)) u_lock (
    .clk     (clk),
    .rst     (rst),
    .wr      (bus_wr),
    .waddr   (bus_waddr),
    .key_in  (bus_wdata[DATA_W-1 -: KEY_W]),
    .en_in   (bus_wdata[0]),
    .lock_on (lock_on)
  );

  assign viol    = bus_wr && (|hit) && lock_on;
  assign stat_rd = bus_rd && (bus_raddr == wpg_pkg::STAT_OFS);

  wpg_vlog #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_vlog (
    .clk       (clk),
    .rst       (rst),
    .viol      (viol),
    .viol_addr (bus_waddr),
    .clr       (stat_rd),
    .flag      (v_flag),
    .src       (v_src)
  );

  assign wr_allow = hit & {N_PROT{bus_wr && !lock_on}};

  always_comb begin
    rd_word = '0;
    if (bus_raddr == wpg_pkg::MODE_OFS) begin
      rd_word[0] = lock_on;
    end else if (bus_raddr == wpg_pkg::STAT_OFS) begin
      rd_word[0] = v_flag;
      rd_word[SRC_LSB +: SRC_W] = v_src;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
    else             bus_rdata <= '0;
  end

  assert_allow_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    (|wr_allow) |-> (bus_wr && $onehot0(wr_allow)));
  assert_locked_block_R6: assert property (@(posedge clk) disable iff (rst)
    lock_on |-> (wr_allow == '0));
  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/sim_wp_guard.sv
module sim_wp_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_waddr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  bus_raddr = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [6:0]  wr_allow;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  wp_guard u0 (
    .clk(clk), .rst(rst),
    .bus_waddr(bus_waddr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_raddr(bus_raddr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .wr_allow(wr_allow)
  );

  localparam logic [31:0] GOOD_ON  = 32'h5353_4301;
  localparam logic [31:0] GOOD_OFF = 32'h5353_4300;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle; allow sampled mid-cycle, rdata after the edge
  task automatic cyc(input logic w, input logic [7:0] wa, input logic [31:0] wd,
                     input logic r, input logic [7:0] ra,
                     output logic [6:0] allow, output logic [31:0] rdat);
    @(negedge clk);
    bus_wr = w; bus_waddr = wa; bus_wdata = wd;
    bus_rd = r; bus_raddr = ra;
    #1 allow = wr_allow;
    @(negedge clk);
    rdat = bus_rdata;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic [6:0] allow);
    logic [31:0] dummy;
    cyc(1'b1, a, d, 1'b0, 8'h00, allow, dummy);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    logic [6:0] dummy;
    cyc(1'b0, 8'h00, 32'h0, 1'b1, a, dummy, d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 wr_allow idle", {25'h0, wr_allow}, 32'h0);
    rd(8'hE4, d); check("R1 mode after reset", d, 32'h0);
    rd(8'hE8, d); check("R1 status after reset", d, 32'h0);
  endtask

  task automatic t_open;
    logic [7:0] ofs [7] = '{8'h04, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h38, 8'h3C};
    logic [6:0] a;
    logic [31:0] d;
    for (int i = 0; i < 7; i++) begin
      wr(ofs[i], 32'hA5A5_0000 + i, a);
      check("R5 allow bit", {25'h0, a}, 32'h1 << i);
    end
    rd(8'hE8, d); check("R5 no log when open", d, 32'h0);
  endtask

  task automatic t_keys;
    logic [6:0] a;
    logic [31:0] d;
    wr(8'hE4, 32'h1234_5601, a);
    rd(8'hE4, d); check("R3 bad key ignored", d, 32'h0);
    wr(8'hE4, GOOD_ON, a);
    rd(8'hE4, d); check("R2 R4 good key on, key reads 0", d, 32'h1);
    wr(8'hE4, 32'h5353_4400, a);
    rd(8'hE4, d); check("R3 near key cannot clear", d, 32'h1);
  endtask

  task automatic t_blocked;
    logic [6:0] a;
    logic [31:0] d;
    wr(8'h14, 32'hFFFF_FFFF, a);
    check("R6 allow held low", {25'h0, a}, 32'h0);
    rd(8'hE8, d); check("R6 logged 0x14", d, 32'h0000_1401);
    rd(8'hE8, d); check("R8 cleared by read", d, 32'h0);
  endtask

  task automatic t_latest;
    logic [6:0] a;
    logic [31:0] d;
    wr(8'h38, 32'h1, a);
    wr(8'h04, 32'h2, a);
    rd(8'hE8, d); check("R7 latest source", d, 32'h0000_0401);
  endtask

  task automatic t_unguarded;
    logic [6:0] a;
    logic [31:0] d;
    wr(8'h20, 32'h77, a);
    check("R10 no allow for unguarded", {25'h0, a}, 32'h0);
    rd(8'hE8, d); check("R10 no log for unguarded", d, 32'h0);
    rd(8'h20, d); check("R11 other offset reads 0", d, 32'h0);
  endtask

  task automatic t_collide;
    logic [6:0] a;
    logic [31:0] d;
    wr(8'h1C, 32'h5, a);
    cyc(1'b1, 8'h3C, 32'h6, 1'b1, 8'hE8, a, d);
    check("R9 read returns old entry", d, 32'h0000_1C01);
    check("R9 blocked in collision", {25'h0, a}, 32'h0);
    rd(8'hE8, d); check("R9 new entry survives clear", d, 32'h0000_3C01);
    rd(8'hE8, d); check("R8 empty after read", d, 32'h0);
  endtask

  task automatic t_unlock;
    logic [6:0] a;
    logic [31:0] d;
    wr(8'hE4, GOOD_OFF, a);
    rd(8'hE4, d); check("R2 good key off", d, 32'h0);
    wr(8'h10, 32'h9, a);
    check("R5 allowed after unlock", {25'h0, a}, 32'h2);
  endtask

  task automatic t_latency;
    logic [31:0] d;
    wr(8'hE4, GOOD_ON, d[6:0]);
    rd(8'hE4, d); check("R11 data after strobe", d, 32'h1);
    @(negedge clk);
    check("R11 idle cycle reads 0", bus_rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_open();
    t_keys();
    t_blocked();
    t_latest();
    t_unguarded();
    t_collide();
    t_unlock();
    t_latency();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule